// File: doc/BRIEF.md
# Fully Associative Micro TLB

This block is a small first-level address translation cache that sits in front of a larger shared translation cache. Each request carries a virtual address, an address-space tag, an access kind and a privilege flag. Every stored translation is compared in parallel with the request. In the same cycle the block returns either a physical address or a miss.

On a hit the block also checks the access against the entry's domain and permission bits, using a 32-bit domain control word. A violation raises an instruction-side abort for fetches, or a data-side abort for loads and stores. On a miss the block raises `busy` and holds a refill request toward the second-level cache. It installs the entry that comes back, and the requester then presents the access again.

Entries map 4 KB, 64 KB, 1 MB or 16 MB pages. Each entry is either global or tagged with an 8-bit address-space identifier, so a context switch needs no flush. Two flush inputs invalidate either everything or only the non-global entries of one identifier.

Top module: `micro_tlb`

## Requirements
- R1: With `req_valid` high and `busy` low, the block compares all entries in parallel. When a valid entry matches, `resp_hit` and `resp_pa` are valid in that same cycle, with no register on the path.
- R2: The page size code is 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB. The address is compared above bit 12, 16, 20 or 24 respectively. The physical address is the entry's frame above that bit, and the request's virtual bits below it.
- R3: A global entry matches any identifier. A non-global entry matches only when `req_asid` equals its stored identifier.
- R4: When several entries match, the translation comes from the lowest-indexed matching entry.
- R5: In a client domain, a fault occurs when any of these holds: the user bit is clear and `req_priv` is 0; a store (kind 2) meets a clear write bit; or a fetch (kind 0) meets a clear execute bit. A load is kind 1.
- R6: The 2-bit field of `dacr` at bits [2d+1:2d], for the entry's domain d, selects the check. 00 and 10 fault on every access, 01 applies R5, and 11 never faults.
- R7: A fault on a hit drives `abort_prefetch` for a fetch and `abort_data` for a load or store. Neither abort is driven without a hit.
- R8: A miss raises `busy` from the next cycle. `busy` stays high, with `refill_req` high and `refill_va`/`refill_asid` holding the missed request, until `refill_ack`. While `busy` is high no request hits.
- R9: `refill_ack` while busy installs the supplied entry and lowers `busy` the next cycle. The target entry is the lowest-indexed invalid entry. When no entry is invalid, a round-robin pointer picks the target, starting at 0 after reset and advancing only when it is used.
- R10: `flush_all` clears every entry. `flush_asid` clears only the non-global entries whose identifier equals `flush_asid_val`. A flush acts after an install made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Current address-space identifier |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 1 | Privileged access |
| dacr | input | 32 | Domain control word, 2 bits per domain |
| resp_hit | output | 1 | Lookup hit this cycle |
| resp_pa | output | PA_W | Translated address, zero on a miss |
| abort_prefetch | output | 1 | Instruction-side abort |
| abort_data | output | 1 | Data-side abort |
| busy | output | 1 | Refill outstanding, port stalled |
| refill_req | output | 1 | Refill request to second level |
| refill_va | output | VA_W | Missed virtual address |
| refill_asid | output | ASID_W | Missed identifier |
| refill_ack | input | 1 | Refill entry supplied |
| refill_ppn | input | PA_W-12 | Physical frame of new entry |
| refill_size | input | 2 | Page size code of new entry |
| refill_global | input | 1 | New entry is global |
| refill_domain | input | 4 | Domain of new entry |
| refill_user | input | 1 | User access allowed |
| refill_write | input | 1 | Store allowed |
| refill_exec | input | 1 | Fetch allowed |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid | input | 1 | Invalidate by identifier |
| flush_asid_val | input | ASID_W | Identifier to invalidate |

## Verification
The bench builds the block with ENTRIES=8 and keeps 32-bit addresses and 8-bit identifiers. With eight entries, the bench can fill the whole store and push it into round-robin replacement in a few refills, so it checks eviction order directly. It also places a 4 KB page and a 1 MB page over the same addresses, which lets it check lowest-index selection and the identifier filter on one pair of entries.

// File: rtl/micro_tlb_pkg.sv
package micro_tlb_pkg;
  localparam int unsigned PAGE_LSB = 12;
  localparam int unsigned DOM_W    = 4;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pgsz_e;

  typedef enum logic [1:0] {
    DOM_DENY    = 2'b00,
    DOM_CLIENT  = 2'b01,
    DOM_RSVD    = 2'b10,
    DOM_MANAGER = 2'b11
  } dmode_e;

  typedef struct packed {
    logic             glob;
    pgsz_e            size;
    logic [DOM_W-1:0] dom;
    logic             p_user;
    logic             p_write;
    logic             p_exec;
  } attr_t;
endpackage

// File: rtl/micro_tlb_prio.sv
// Lowest-index-wins priority encoder.
module micro_tlb_prio #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]                  req,
  output logic                          found,
  output logic [((N>1)?$clog2(N):1)-1:0] idx
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/micro_tlb_match.sv
// Parallel tag compare, one comparator per entry.
module micro_tlb_match
  import micro_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 8
) (
  input  logic [VPN_W-1:0]   va_vpn,
  input  logic [ASID_W-1:0]  cur_asid,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
  input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
  input  logic [ENTRIES-1:0] ent_glob,
  input  pgsz_e              ent_size [ENTRIES],
  output logic [ENTRIES-1:0] hit_vec
);
  function automatic logic [VPN_W-1:0] care_mask(pgsz_e s);
    logic [VPN_W-1:0] m;
    m = '1;
    m = m << (4 * int'(s));
    return m;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] care;
    logic             tag_eq;
    logic             asid_ok;
    always_comb begin
      care    = care_mask(ent_size[g]);
      tag_eq  = ((va_vpn ^ ent_vpn[g]) & care) == '0;
      asid_ok = ent_glob[g] || (ent_asid[g] == cur_asid);
    end
    assign hit_vec[g] = ent_valid[g] && tag_eq && asid_ok;
  end
endmodule

// File: rtl/micro_tlb_perm.sv
// Domain and permission check for the selected entry.
module micro_tlb_perm
  import micro_tlb_pkg::*;
(
  input  logic [31:0]      dacr,
  input  logic [DOM_W-1:0] dom,
  input  logic             p_user,
  input  logic             p_write,
  input  logic             p_exec,
  input  acc_e             kind,
  input  logic             priv,
  output logic             fault
);
  dmode_e mode;

  always_comb begin
    mode = dmode_e'(dacr[2*dom +: 2]);
    unique case (mode)
      DOM_CLIENT:  fault = (!priv && !p_user)
                         || (kind == ACC_STORE && !p_write)
                         || (kind == ACC_FETCH && !p_exec);
      DOM_MANAGER: fault = 1'b0;
      default:     fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/micro_tlb_store.sv
// Entry storage, victim choice and flush handling.
module micro_tlb_store
  import micro_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned ASID_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_en,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [PPN_W-1:0]   ins_ppn,
  input  logic [ASID_W-1:0]  ins_asid,
  input  attr_t              ins_attr,
  input  logic               flush_all,
  input  logic               flush_asid,
  input  logic [ASID_W-1:0]  flush_asid_val,
  output logic [ENTRIES-1:0] valid,
  output logic [VPN_W-1:0]   vpn  [ENTRIES],
  output logic [PPN_W-1:0]   ppn  [ENTRIES],
  output logic [ASID_W-1:0]  asid [ENTRIES],
  output attr_t              attr [ENTRIES]
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, valid_d, load;
  logic [IDX_W-1:0]   rr_q, rr_d, free_idx, victim;
  logic               free_any;

  micro_tlb_prio #(.N(ENTRIES)) u_free (
    .req   (~valid_q),
    .found (free_any),
    .idx   (free_idx)
  );

  assign victim = free_any ? free_idx : rr_q;

  always_comb begin
    rr_d = rr_q;
    if (ins_en && !free_any) begin
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      load[i] = ins_en && (victim == IDX_W'(i));
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic             g_post;
      logic [ASID_W-1:0] a_post;
      g_post     = load[i] ? ins_attr.glob : attr[i].glob;
      a_post     = load[i] ? ins_asid : asid[i];
      valid_d[i] = valid_q[i] | load[i];
      if (flush_all) begin
        valid_d[i] = 1'b0;
      end else if (flush_asid && !g_post && a_post == flush_asid_val) begin
        valid_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (load[g]) begin
        vpn[g]  <= ins_vpn;
        ppn[g]  <= ins_ppn;
        asid[g] <= ins_asid;
        attr[g] <= ins_attr;
      end
    end
  end

  assign valid = valid_q;
endmodule

// File: rtl/micro_tlb.sv
module micro_tlb
  import micro_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned ASID_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_va,
  input  logic [ASID_W-1:0]        req_asid,
  input  logic [1:0]               req_kind,
  input  logic                     req_priv,
  input  logic [31:0]              dacr,
  output logic                     resp_hit,
  output logic [PA_W-1:0]          resp_pa,
  output logic                     abort_prefetch,
  output logic                     abort_data,
  output logic                     busy,
  output logic                     refill_req,
  output logic [VA_W-1:0]          refill_va,
  output logic [ASID_W-1:0]        refill_asid,
  input  logic                     refill_ack,
  input  logic [PA_W-PAGE_LSB-1:0] refill_ppn,
  input  logic [1:0]               refill_size,
  input  logic                     refill_global,
  input  logic [DOM_W-1:0]         refill_domain,
  input  logic                     refill_user,
  input  logic                     refill_write,
  input  logic                     refill_exec,
  input  logic                     flush_all,
  input  logic                     flush_asid,
  input  logic [ASID_W-1:0]        flush_asid_val
);
  localparam int unsigned VPN_W = VA_W - PAGE_LSB;
  localparam int unsigned PPN_W = PA_W - PAGE_LSB;
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry store
  logic [ENTRIES-1:0] ent_valid;
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  attr_t              ent_attr [ENTRIES];
  logic [ENTRIES-1:0] ent_glob;
  pgsz_e              ent_size [ENTRIES];

  // refill tracking
  logic              busy_q, busy_d, cap_en, ins_en;
  logic [VA_W-1:0]   pend_va_q;
  logic [ASID_W-1:0] pend_asid_q;
  attr_t             ins_attr;

  // lookup
  logic              lookup_en, hit_any, fault;
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]  hit_idx;
  attr_t             sel_attr;
  logic [PA_W-1:0]   sel_base, off_mask, pa_full;
  acc_e              kind;

  always_comb begin
    ins_attr.glob    = refill_global;
    ins_attr.size    = pgsz_e'(refill_size);
    ins_attr.dom     = refill_domain;
    ins_attr.p_user  = refill_user;
    ins_attr.p_write = refill_write;
    ins_attr.p_exec  = refill_exec;
  end

  assign ins_en = busy_q && refill_ack;

  micro_tlb_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .ASID_W  (ASID_W)
  ) u_store (
    .clk            (clk),
    .rst_n          (rst_n),
    .ins_en         (ins_en),
    .ins_vpn        (pend_va_q[VA_W-1:PAGE_LSB]),
    .ins_ppn        (refill_ppn),
    .ins_asid       (pend_asid_q),
    .ins_attr       (ins_attr),
    .flush_all      (flush_all),
    .flush_asid     (flush_asid),
    .flush_asid_val (flush_asid_val),
    .valid          (ent_valid),
    .vpn            (ent_vpn),
    .ppn            (ent_ppn),
    .asid           (ent_asid),
    .attr           (ent_attr)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_split
    assign ent_glob[g] = ent_attr[g].glob;
    assign ent_size[g] = ent_attr[g].size;
  end

  micro_tlb_match #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASID_W  (ASID_W)
  ) u_match (
    .va_vpn    (req_va[VA_W-1:PAGE_LSB]),
    .cur_asid  (req_asid),
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_asid  (ent_asid),
    .ent_glob  (ent_glob),
    .ent_size  (ent_size),
    .hit_vec   (hit_vec)
  );

  micro_tlb_prio #(.N(ENTRIES)) u_sel (
    .req   (hit_vec),
    .found (hit_any),
    .idx   (hit_idx)
  );

  assign kind     = acc_e'(req_kind);
  assign sel_attr = ent_attr[hit_idx];

  micro_tlb_perm u_perm (
    .dacr    (dacr),
    .dom     (sel_attr.dom),
    .p_user  (sel_attr.p_user),
    .p_write (sel_attr.p_write),
    .p_exec  (sel_attr.p_exec),
    .kind    (kind),
    .priv    (req_priv),
    .fault   (fault)
  );

  // address assembly: frame above the page boundary, request offset below
  always_comb begin
    sel_base = {ent_ppn[hit_idx], {PAGE_LSB{1'b0}}};
    off_mask = (PA_W'(1) << (PAGE_LSB + 4 * int'(sel_attr.size))) - PA_W'(1);
    pa_full  = (sel_base & ~off_mask) | (PA_W'(req_va[23:0]) & off_mask);
  end

  assign lookup_en      = req_valid && !busy_q;
  assign resp_hit       = lookup_en && hit_any;
  assign resp_pa        = resp_hit ? pa_full : '0;
  assign abort_prefetch = resp_hit && fault && (kind == ACC_FETCH);
  assign abort_data     = resp_hit && fault && (kind != ACC_FETCH);

  // refill control: next state
  always_comb begin
    cap_en = lookup_en && !hit_any;
    if (busy_q) busy_d = !refill_ack;
    else        busy_d = cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      pend_va_q   <= req_va;
      pend_asid_q <= req_asid;
    end
  end

  assign busy        = busy_q;
  assign refill_req  = busy_q;
  assign refill_va   = pend_va_q;
  assign refill_asid = pend_asid_q;
endmodule

// File: rtl/micro_tlb_chk.sv
module micro_tlb_chk #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_kind,
  input logic               resp_hit,
  input logic               abort_prefetch,
  input logic               abort_data,
  input logic               busy,
  input logic [VA_W-1:0]    refill_va,
  input logic               refill_ack,
  input logic               flush_all,
  input logic               flush_asid,
  input logic [ENTRIES-1:0] ent_valid
);
  AST_HIT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> (req_valid && !busy)); // R8
  AST_ABORT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_prefetch || abort_data) |-> resp_hit); // R7
  AST_ABORT_SIDE_I: assert property (@(posedge clk) disable iff (!rst_n)
    abort_prefetch |-> (req_kind == 2'd0)); // R7
  AST_ABORT_SIDE_D: assert property (@(posedge clk) disable iff (!rst_n)
    abort_data |-> (req_kind != 2'd0)); // R7
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !resp_hit) |=> busy); // R8
  AST_BUSY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !refill_ack) |=> (busy && $stable(refill_va))); // R8
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && refill_ack) |=> !busy); // R9
  AST_INSTALL_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && refill_ack && !flush_all && !flush_asid && !(&ent_valid))
      |=> ($countones(ent_valid) == $countones($past(ent_valid)) + 1)); // R9
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (ent_valid == '0)); // R10
endmodule

bind micro_tlb micro_tlb_chk #(
  .ENTRIES (ENTRIES),
  .VA_W    (VA_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_kind       (req_kind),
  .resp_hit       (resp_hit),
  .abort_prefetch (abort_prefetch),
  .abort_data     (abort_data),
  .busy           (busy),
  .refill_va      (refill_va),
  .refill_ack     (refill_ack),
  .flush_all      (flush_all),
  .flush_asid     (flush_asid),
  .ent_valid      (ent_valid)
);

// File: tb/micro_tlb_test.sv
`timescale 1ns/1ps
module micro_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_priv;
  logic [31:0] req_va, dacr;
  logic [7:0]  req_asid;
  logic [1:0]  req_kind;
  logic        resp_hit, abort_prefetch, abort_data, busy, refill_req;
  logic [31:0] resp_pa, refill_va;
  logic [7:0]  refill_asid;
  logic        refill_ack, refill_global, refill_user, refill_write, refill_exec;
  logic [19:0] refill_ppn;
  logic [1:0]  refill_size;
  logic [3:0]  refill_domain;
  logic        flush_all, flush_asid;
  logic [7:0]  flush_asid_val;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  micro_tlb #(.ENTRIES(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_asid(req_asid), .req_kind(req_kind), .req_priv(req_priv), .dacr(dacr),
    .resp_hit(resp_hit), .resp_pa(resp_pa), .abort_prefetch(abort_prefetch),
    .abort_data(abort_data), .busy(busy), .refill_req(refill_req),
    .refill_va(refill_va), .refill_asid(refill_asid), .refill_ack(refill_ack),
    .refill_ppn(refill_ppn), .refill_size(refill_size), .refill_global(refill_global),
    .refill_domain(refill_domain), .refill_user(refill_user), .refill_write(refill_write),
    .refill_exec(refill_exec), .flush_all(flush_all), .flush_asid(flush_asid),
    .flush_asid_val(flush_asid_val)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic [1:0]  kind;
    logic        priv;
    logic [31:0] pa;
    logic        pabt;
    logic        dabt;
  } vec_t;

  // kind: 0 fetch, 1 load, 2 store
  localparam vec_t VECS [12] = '{
    '{32'h0000_1234, 8'd5, 2'd1, 1'b0, 32'h8000_1234, 1'b0, 1'b0}, // R4 lowest index wins
    '{32'h0000_1234, 8'd6, 2'd1, 1'b0, 32'hC000_1234, 1'b0, 1'b0}, // R3 asid filter
    '{32'h0000_1ABC, 8'd5, 2'd2, 1'b0, 32'h8000_1ABC, 1'b0, 1'b1}, // R5 write denied
    '{32'h0000_1ABC, 8'd5, 2'd0, 1'b0, 32'h8000_1ABC, 1'b0, 1'b0}, // R5 exec ok
    '{32'h0012_F00D, 8'd9, 2'd1, 1'b1, 32'h9000_F00D, 1'b0, 1'b0}, // R2 64K, priv
    '{32'h0012_F00D, 8'd9, 2'd1, 1'b0, 32'h9000_F00D, 1'b0, 1'b1}, // R5 user denied
    '{32'h0012_F00D, 8'd9, 2'd0, 1'b1, 32'h9000_F00D, 1'b1, 1'b0}, // R7 fetch abort
    '{32'h030A_BCDE, 8'd1, 2'd0, 1'b0, 32'hA03A_BCDE, 1'b0, 1'b0}, // R6 manager, R2 1M
    '{32'h0512_3456, 8'd1, 2'd1, 1'b1, 32'hB012_3456, 1'b0, 1'b1}, // R6 deny, R2 16M
    '{32'h0512_3456, 8'd1, 2'd0, 1'b1, 32'hB012_3456, 1'b1, 1'b0}, // R7 deny on fetch
    '{32'h0000_2345, 8'd7, 2'd2, 1'b0, 32'hC000_2345, 1'b0, 1'b0}, // R3 global
    '{32'h0012_0004, 8'd2, 2'd2, 1'b1, 32'h9000_0004, 1'b0, 1'b0}  // R1 store allowed
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic probe(input logic [31:0] va, input logic [7:0] asid,
                       input logic [1:0] kind, input logic priv);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_asid = asid; req_kind = kind; req_priv = priv;
    #1;
  endtask

  task automatic refill(input logic [31:0] va, input logic [7:0] asid, input logic [19:0] ppn,
                        input logic [1:0] sz, input logic g, input logic [3:0] d,
                        input logic u, input logic w, input logic x);
    probe(va, asid, 2'd1, 1'b1);
    chk("R8 miss gives no hit", resp_hit, 0);
    @(negedge clk); #1;
    chk("R8 busy after miss", busy, 1);
    chk("R8 refill_req held", refill_req, 1);
    chk("R8 refill_va", refill_va, va);
    chk("R8 no hit while stalled", resp_hit, 0);
    req_valid = 1'b0;
    refill_ack = 1'b1; refill_ppn = ppn; refill_size = sz; refill_global = g;
    refill_domain = d; refill_user = u; refill_write = w; refill_exec = x;
    @(negedge clk);
    refill_ack = 1'b0;
    #1;
    chk("R9 busy released after ack", busy, 0);
  endtask

  task automatic pulse_flush(input logic all, input logic [7:0] id);
    @(negedge clk);
    flush_all = all; flush_asid = !all; flush_asid_val = id;
    @(negedge clk);
    flush_all = 1'b0; flush_asid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_asid = '0; req_kind = '0;
    req_priv = 1'b0; dacr = 32'h0000_000D; refill_ack = 1'b0; refill_ppn = '0;
    refill_size = '0; refill_global = 1'b0; refill_domain = '0; refill_user = 1'b0;
    refill_write = 1'b0; refill_exec = 1'b0; flush_all = 1'b0; flush_asid = 1'b0;
    flush_asid_val = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset busy low", busy, 0);
    chk("R8 reset refill_req low", refill_req, 0);
    chk("R1 reset no hit", resp_hit, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // domains: 0 client, 1 manager, 2 deny
    refill(32'h0000_1000, 8'd5, 20'h80001, 2'd0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1);
    refill(32'h0012_0000, 8'd5, 20'h90000, 2'd1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0);
    refill(32'h0300_0000, 8'd5, 20'hA0300, 2'd2, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0);
    refill(32'h0500_0000, 8'd5, 20'hB0000, 2'd3, 1'b1, 4'd2, 1'b1, 1'b1, 1'b1);
    refill(32'h0000_2000, 8'd5, 20'hC0000, 2'd2, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1);

    for (int i = 0; i < 12; i++) begin
      probe(VECS[i].va, VECS[i].asid, VECS[i].kind, VECS[i].priv);
      chk($sformatf("R1 hit row %0d", i), resp_hit, 1);
      chk($sformatf("R2 pa row %0d", i), resp_pa, VECS[i].pa);
      chk($sformatf("R7 prefetch abort row %0d", i), abort_prefetch, VECS[i].pabt);
      chk($sformatf("R7 data abort row %0d", i), abort_data, VECS[i].dabt);
    end

    // reserved domain code faults
    dacr = 32'h0000_000E;
    probe(32'h0000_1234, 8'd5, 2'd1, 1'b1);
    chk("R6 reserved code data abort", abort_data, 1);
    chk("R6 reserved code no prefetch abort", abort_prefetch, 0);
    dacr = 32'h0000_000D;
    req_valid = 1'b0;

    // flush by identifier keeps the global entry
    pulse_flush(1'b0, 8'd5);
    probe(32'h0000_1234, 8'd5, 2'd1, 1'b0);
    chk("R10 asid flush falls to global entry", resp_pa, 32'hC000_1234);
    probe(32'h0012_0004, 8'd5, 2'd1, 1'b1);
    chk("R10 global survives asid flush", resp_hit, 1);
    req_valid = 1'b0;

    // flush all
    pulse_flush(1'b1, 8'd0);
    probe(32'h0000_2345, 8'd7, 2'd1, 1'b1);
    chk("R10 flush all empties store", resp_hit, 0);
    @(negedge clk);
    req_valid = 1'b0; refill_ack = 1'b1;
    @(negedge clk);
    refill_ack = 1'b0;
    pulse_flush(1'b1, 8'd0);

    // fill 8 entries, then round-robin replacement
    for (int k = 0; k < 8; k++) begin
      refill(32'(k) << 12, 8'd1, 20'h10000 + 20'(k), 2'd0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1);
    end
    refill(32'h0004_0000, 8'd1, 20'h10040, 2'd0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1);
    refill(32'h0000_0000, 8'd1, 20'h10000, 2'd0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1); // R9 slot 0 evicted
    refill(32'h0000_1000, 8'd1, 20'h10001, 2'd0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1); // R9 slot 1 evicted
    probe(32'h0004_0000, 8'd1, 2'd1, 1'b1);
    chk("R9 round-robin kept new entry", resp_pa, 32'h1004_0000);
    probe(32'h0000_3ABC, 8'd1, 2'd1, 1'b1);
    chk("R9 untouched slot still hits", resp_pa, 32'h1000_3ABC);
    probe(32'h0000_2000, 8'd1, 2'd1, 1'b1);
    chk("R9 slot 2 evicted by third replacement", resp_hit, 0);
    req_valid = 1'b0;

    finish_run();
  end
endmodule